// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a small data cache controller placed between a processor load/store port and a word-wide memory port. It keeps two ways of four-word lines per set, each line with its own valid and dirty state, and one replacement bit per set. Loads and stores that hit are answered in a single lookup. Partial stores merge into the cached line through byte enables. A modified line reaches memory only when it is chosen as a victim.

On a miss the controller first writes back a dirty victim, then fills the line. The fill starts at the word the processor asked for and wraps around the line. Load data is handed to the processor as soon as that first word arrives. Stores that miss allocate the line and merge their bytes into the fetched word.

A mask input holds one cacheability bit per 128MB region, selected by the top five address bits. An access to a region whose bit is clear goes straight to memory as one beat and leaves the arrays untouched. The processor keeps its request and fields steady until it sees the one-cycle acknowledge.

Top module: `l1d_wb_cache`

## Requirements
- R1: While rst_ni is low and right after it rises, ack_o and mem_req_o are low. All lines are invalid, so the first access to any cacheable address starts a line fill.
- R2: A load or store hit raises ack_o one cycle after the request is presented and makes no memory beat. A load hit returns the stored word on rdata_o.
- R3: A store hit writes only the bytes whose be_i bit is set (bit n covers data bits 8n+7:8n). Later loads of that word return the merged value.
- R4: A fill makes four read beats to the line address. The first beat is at the requested word, and each following beat is the next word index modulo four.
- R5: On a load miss, ack_o rises in the cycle after the requested word's beat completes, and rdata_o carries that word.
- R6: A store miss fetches the line, merges the enabled store bytes into the requested word and leaves the line dirty. Later hits return the merged word.
- R7: The victim is way 0 if it is invalid, else way 1 if it is invalid, else the way not used most recently. Every hit and fill counts as a use of its way.
- R8: A dirty victim is written as four write beats to its own line address, words 0 to 3 in order, before the first fill beat. A clean victim causes no write beat.
- R9: An access whose region bit in cacheable_i (index addr_i[31:27]) is 0 makes exactly one memory beat with the request's address, direction and byte enables. It allocates nothing, so repeating it makes another beat.
- R10: While mem_req_o is high and mem_ready_i is low, mem_req_o, mem_addr_o and mem_we_o hold their values.
- R11: ack_o is high for exactly one cycle per request, and no request is taken in the cycle ack_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cacheable_i | input | 32 | One cacheability bit per 128MB region |
| req_i | input | 1 | Processor access request, held until ack_o |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 32 | Byte address |
| be_i | input | 4 | Store byte enables |
| wdata_i | input | 32 | Store data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Load data, valid with ack_o |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Memory beat is a write |
| mem_addr_o | output | 32 | Memory word address |
| mem_be_o | output | 4 | Memory byte enables |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts or completes the beat this cycle |
| mem_rdata_i | input | 32 | Memory read data, valid when ready |

## Verification
With memory ready held high, a hit acknowledges one cycle after the request and a clean miss or a bypass after two. A miss with a dirty victim acknowledges after six, because four write beats come before the first fill beat. The bench counts falling edges from the request to the acknowledge and compares the count with these values. Memory beats are logged at the rising edge and checked only after a drain period, once the trailing fill beats have finished. Load data is compared by a scoreboard against a flat image of memory as the processor sees it.

// File: rtl/l1d_pkg.sv
package l1d_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL, ST_BYP} st_e;
endpackage

// File: rtl/l1d_tag_store.sv
module l1d_tag_store #(
  parameter int SETS  = 256,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IDX_W-1:0]      rd_set_i,
  output logic [1:0][TAG_W-1:0] rd_tag_o,
  output logic [1:0]            rd_valid_o,
  output logic [1:0]            rd_dirty_o,
  output logic                  rd_lru_o,
  input  logic [IDX_W-1:0]      upd_set_i,
  input  logic                  upd_way_i,
  input  logic                  touch_i,
  input  logic                  mark_dirty_i,
  input  logic                  alloc_i,
  input  logic [TAG_W-1:0]      alloc_tag_i,
  input  logic                  alloc_dirty_i
);
  logic [SETS-1:0] lru_q;  // way to evict next

  for (genvar w = 0; w < 2; w++) begin : g_way
    localparam logic WAY_ID = 1'(w);
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (upd_way_i == WAY_ID) begin
        if (alloc_i) begin
          valid_q[upd_set_i] <= 1'b1;
          dirty_q[upd_set_i] <= alloc_dirty_i;
        end else if (mark_dirty_i) begin
          dirty_q[upd_set_i] <= 1'b1;
        end
      end
    end

    always_ff @(posedge clk_i) begin
      if (alloc_i && upd_way_i == WAY_ID) tag_q[upd_set_i] <= alloc_tag_i;
    end

    assign rd_tag_o[w]   = tag_q[rd_set_i];
    assign rd_valid_o[w] = valid_q[rd_set_i];
    assign rd_dirty_o[w] = dirty_q[rd_set_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lru_q <= '0;
    else if (touch_i) lru_q[upd_set_i] <= ~upd_way_i;
  end

  assign rd_lru_o = lru_q[rd_set_i];
endmodule

// File: rtl/l1d_data_store.sv
module l1d_data_store #(
  parameter int SETS   = 256,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WOFF_W = $clog2(WORDS),
  localparam int BYTES = DATA_W / 8
) (
  input  logic                   clk_i,
  input  logic [IDX_W-1:0]       rd_set_i,
  input  logic [WOFF_W-1:0]      rd_word_i,
  output logic [1:0][DATA_W-1:0] rd_data_o,
  input  logic                   wr_en_i,
  input  logic                   wr_way_i,
  input  logic [IDX_W-1:0]       wr_set_i,
  input  logic [WOFF_W-1:0]      wr_word_i,
  input  logic [BYTES-1:0]       wr_be_i,
  input  logic [DATA_W-1:0]      wr_data_i
);
  localparam int DEPTH = SETS * WORDS;

  for (genvar w = 0; w < 2; w++) begin : g_way
    localparam logic WAY_ID = 1'(w);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_way_i == WAY_ID) begin
        for (int b = 0; b < BYTES; b++) begin
          if (wr_be_i[b]) mem_q[{wr_set_i, wr_word_i}][8*b +: 8] <= wr_data_i[8*b +: 8];
        end
      end
    end

    assign rd_data_o[w] = mem_q[{rd_set_i, rd_word_i}];
  end
endmodule

// File: rtl/l1d_wb_cache.sv
module l1d_wb_cache #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int SETS    = 256,
  parameter int WORDS   = 4,
  parameter int REGIONS = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [REGIONS-1:0]   cacheable_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W/8-1:0]  be_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 ack_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [DATA_W/8-1:0]  mem_be_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  input  logic                 mem_ready_i,
  input  logic [DATA_W-1:0]    mem_rdata_i
);
  import l1d_pkg::*;

  localparam int BYTES  = DATA_W / 8;
  localparam int BOFF_W = $clog2(BYTES);
  localparam int WOFF_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;
  localparam int REG_W  = $clog2(REGIONS);
  localparam logic [WOFF_W-1:0] LAST_WORD = WOFF_W'(WORDS - 1);

  st_e                 state_q, state_d;
  logic [WOFF_W-1:0]   cnt_q, cnt_d;
  logic                vway_q, vway_d;
  logic [ADDR_W-1:0]   addr_q;
  logic                we_q;
  logic [BYTES-1:0]    be_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                ack_q, ack_d;
  logic [DATA_W-1:0]   rdata_q, rdata_d;

  logic                idle, accept, cacheable, beat_done;
  logic [IDX_W-1:0]    cur_idx;
  logic [TAG_W-1:0]    cur_tag;
  logic [WOFF_W-1:0]   cur_word, fill_word, rd_word;
  logic [1:0]          hit_vec;
  logic                hit, hit_way, victim;
  logic [DATA_W-1:0]   merged;

  logic [1:0][TAG_W-1:0]  rd_tag;
  logic [1:0]             rd_valid, rd_dirty;
  logic                   rd_lru;
  logic [1:0][DATA_W-1:0] rd_data;

  logic                t_touch, t_dirty, t_alloc, upd_way;
  logic                dw_en, dw_way;
  logic [WOFF_W-1:0]   dw_word;
  logic [BYTES-1:0]    dw_be;
  logic [DATA_W-1:0]   dw_data;

  assign idle      = (state_q == ST_IDLE);
  assign accept    = idle && req_i && !ack_q;
  assign cacheable = cacheable_i[addr_i[ADDR_W-1 -: REG_W]];
  assign cur_idx   = idle ? addr_i[BOFF_W+WOFF_W +: IDX_W] : addr_q[BOFF_W+WOFF_W +: IDX_W];
  assign cur_tag   = idle ? addr_i[ADDR_W-1 -: TAG_W] : addr_q[ADDR_W-1 -: TAG_W];
  assign cur_word  = idle ? addr_i[BOFF_W +: WOFF_W] : addr_q[BOFF_W +: WOFF_W];
  assign fill_word = addr_q[BOFF_W +: WOFF_W] + cnt_q;
  assign rd_word   = (state_q == ST_WB) ? cnt_q : cur_word;
  assign beat_done = mem_req_o && mem_ready_i;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == cur_tag);
  end
  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];
  // invalid way first, way 0 before way 1, then LRU
  assign victim  = !rd_valid[0] ? 1'b0 : (!rd_valid[1] ? 1'b1 : rd_lru);

  always_comb begin
    for (int b = 0; b < BYTES; b++) begin
      merged[8*b +: 8] = be_q[b] ? wdata_q[8*b +: 8] : mem_rdata_i[8*b +: 8];
    end
  end

  l1d_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_set_i     (cur_idx),
    .rd_tag_o     (rd_tag),
    .rd_valid_o   (rd_valid),
    .rd_dirty_o   (rd_dirty),
    .rd_lru_o     (rd_lru),
    .upd_set_i    (cur_idx),
    .upd_way_i    (upd_way),
    .touch_i      (t_touch),
    .mark_dirty_i (t_dirty),
    .alloc_i      (t_alloc),
    .alloc_tag_i  (cur_tag),
    .alloc_dirty_i(we_q)
  );

  l1d_data_store #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
    .clk_i    (clk_i),
    .rd_set_i (cur_idx),
    .rd_word_i(rd_word),
    .rd_data_o(rd_data),
    .wr_en_i  (dw_en),
    .wr_way_i (dw_way),
    .wr_set_i (cur_idx),
    .wr_word_i(dw_word),
    .wr_be_i  (dw_be),
    .wr_data_i(dw_data)
  );

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    vway_d      = vway_q;
    ack_d       = 1'b0;
    rdata_d     = rdata_q;
    t_touch     = 1'b0;
    t_dirty     = 1'b0;
    t_alloc     = 1'b0;
    upd_way     = vway_q;
    dw_en       = 1'b0;
    dw_way      = vway_q;
    dw_word     = cur_word;
    dw_be       = '1;
    dw_data     = mem_rdata_i;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = addr_q;
    mem_be_o    = '1;
    mem_wdata_o = wdata_q;

    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!cacheable) begin
            state_d = ST_BYP;
          end else if (hit) begin
            t_touch = 1'b1;
            upd_way = hit_way;
            ack_d   = 1'b1;
            rdata_d = rd_data[hit_way];
            if (we_i) begin
              t_dirty = 1'b1;
              dw_en   = 1'b1;
              dw_way  = hit_way;
              dw_be   = be_i;
              dw_data = wdata_i;
            end
          end else begin
            vway_d  = victim;
            cnt_d   = '0;
            state_d = (rd_valid[victim] && rd_dirty[victim]) ? ST_WB : ST_FILL;
          end
        end
      end

      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {rd_tag[vway_q], cur_idx, cnt_q, {BOFF_W{1'b0}}};
        mem_wdata_o = rd_data[vway_q];
        if (mem_ready_i) begin
          cnt_d = cnt_q + WOFF_W'(1);
          if (cnt_q == LAST_WORD) state_d = ST_FILL;
        end
      end

      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {cur_tag, cur_idx, fill_word, {BOFF_W{1'b0}}};
        if (mem_ready_i) begin
          dw_en   = 1'b1;
          dw_word = fill_word;
          // requested word arrives first: forward it, merge a store into it
          if (cnt_q == '0) begin
            ack_d   = 1'b1;
            rdata_d = mem_rdata_i;
            if (we_q) dw_data = merged;
          end
          cnt_d = cnt_q + WOFF_W'(1);
          if (cnt_q == LAST_WORD) begin
            t_alloc = 1'b1;
            t_touch = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end

      ST_BYP: begin
        mem_req_o = 1'b1;
        mem_we_o  = we_q;
        mem_be_o  = be_q;
        if (mem_ready_i) begin
          ack_d   = 1'b1;
          rdata_d = mem_rdata_i;
          state_d = ST_IDLE;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vway_q  <= 1'b0;
      ack_q   <= 1'b0;
      rdata_q <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      vway_q  <= vway_d;
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
      if (accept) begin
        addr_q  <= addr_i;
        we_q    <= we_i;
        be_q    <= be_i;
        wdata_q <= wdata_i;
      end
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;

  logic unused_beat;
  assign unused_beat = beat_done;
endmodule

// File: rtl/l1d_wb_cache_chk.sv
module l1d_wb_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic               mem_ready_i,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input l1d_pkg::st_e       state_q
);
  import l1d_pkg::*;
  localparam int BOFF_W = $clog2(DATA_W / 8);
  localparam int WOFF_W = $clog2(WORDS);
  localparam int CNT_W  = $clog2(WORDS) + 1;

  logic [CNT_W-1:0] wb_beats;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       wb_beats <= '0;
    else if (state_q == ST_IDLE)                       wb_beats <= '0;
    else if (state_q == ST_WB && mem_req_o && mem_ready_i) wb_beats <= wb_beats + CNT_W'(1);
  end

  // R11
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R10
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R8
  wb_done_before_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && $past(state_q) == ST_WB) |-> (wb_beats == CNT_W'(WORDS)));

  // R4
  fill_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && mem_ready_i) |=>
      (state_q != ST_FILL ||
       mem_addr_o[BOFF_W +: WOFF_W] == WOFF_W'($past(mem_addr_o[BOFF_W +: WOFF_W]) + 1'b1)));

  // R9
  bypass_single_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BYP && mem_ready_i) |=> (state_q == ST_IDLE && ack_o));

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !mem_req_o);
endmodule

bind l1d_wb_cache l1d_wb_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_o      (ack_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_ready_i(mem_ready_i),
  .mem_addr_o (mem_addr_o),
  .state_q    (state_q)
);

// File: tb/tb_l1d_wb_cache.sv
module tb_l1d_wb_cache;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] cacheable_i = 32'hFFFF_FFFD;  // region 1 uncached
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [3:0]  be_i = '0;
  logic        ack_o;
  logic [31:0] rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [3:0]  mem_be_o;
  logic        mem_ready_i = 1'b1;

  always #5 clk = ~clk;

  l1d_wb_cache dut (
    .clk_i(clk), .rst_ni(rst_ni), .cacheable_i(cacheable_i),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .be_i(be_i), .wdata_i(wdata_i),
    .ack_o(ack_o), .rdata_o(rdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
  );

  int n_chk = 0, n_fail = 0;
  bit rnd_mode = 1'b0;
  bit done = 1'b0;

  // memory model, word index addr[13:2]
  logic [31:0] bmem [4096];
  logic [31:0] gmem [4096];
  int          log_n = 0;
  logic        log_we [1024];
  logic [31:0] log_addr [1024];

  assign mem_rdata_i = bmem[mem_addr_o[13:2]];

  always @(posedge clk) begin
    if (mem_req_o && mem_ready_i) begin
      if (log_n < 1024) begin
        log_we[log_n]   <= mem_we_o;
        log_addr[log_n] <= mem_addr_o;
      end
      log_n <= log_n + 1;
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) bmem[mem_addr_o[13:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
      end
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      bmem[i] <= 32'(i) * 32'h9E37_79B1 + 32'h0000_5A5A;
      gmem[i]  = 32'(i) * 32'h9E37_79B1 + 32'h0000_5A5A;
    end
  end

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    forever begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mem_ready_i = rnd_mode ? (lf[0] | lf[3]) : 1'b1;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // scoreboard
  logic [32:0] exp_q [$];
  string       tag_q [$];

  initial begin
    forever begin
      @(negedge clk);
      if (ack_o) begin
        if (exp_q.size() == 0) begin
          chk("R11", "unexpected ack", 32'd1, 32'd0);
        end else begin
          logic [32:0] it;
          string t;
          it = exp_q.pop_front();
          t  = tag_q.pop_front();
          if (it[32]) chk(t, "load data", rdata_o, it[31:0]);
        end
      end
    end
  end

  int last_lat;
  int mark;

  task automatic access(input bit we, input logic [31:0] a, input logic [3:0] be,
                        input logic [31:0] wd, input string tag);
    int lat;
    if (!we) exp_q.push_back({1'b1, gmem[a[13:2]]});
    else begin
      exp_q.push_back({1'b0, 32'h0});
      for (int b = 0; b < 4; b++) if (be[b]) gmem[a[13:2]][8*b +: 8] = wd[8*b +: 8];
    end
    tag_q.push_back(tag);
    @(negedge clk);
    mark    = log_n;
    req_i   = 1'b1;
    we_i    = we;
    addr_i  = a;
    be_i    = be;
    wdata_i = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ack_o && lat < 500);
    if (!ack_o) chk(tag, "ack timeout", 32'(lat), 32'd0);
    req_i = 1'b0;
    last_lat = lat;
    @(negedge clk);
    chk("R11", "ack width", {31'd0, ack_o}, 32'd0);
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
  endtask

  task automatic chk_beat(input string tag, input int k, input bit we, input logic [31:0] a);
    chk(tag, $sformatf("beat %0d dir", k), {31'd0, log_we[mark + k]}, {31'd0, we});
    chk(tag, $sformatf("beat %0d addr", k), log_addr[mark + k], a);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog: got %0d cycles expected completion", 100000);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ack in reset", {31'd0, ack_o}, 32'd0);
    chk("R1", "mem_req in reset", {31'd0, mem_req_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "ack after reset", {31'd0, ack_o}, 32'd0);
    chk("R1", "mem_req after reset", {31'd0, mem_req_o}, 32'd0);

    // R1 R4 R5 first load misses, fill starts at word 2 and wraps
    access(0, 32'h0000_0108, 4'hF, 0, "R5");
    chk("R5", "miss latency", 32'(last_lat), 32'd2);
    drain();
    chk("R1", "fill beats", 32'(log_n - mark), 32'd4);
    chk_beat("R4", 0, 0, 32'h0000_0108);
    chk_beat("R4", 1, 0, 32'h0000_010C);
    chk_beat("R4", 2, 0, 32'h0000_0100);
    chk_beat("R4", 3, 0, 32'h0000_0104);

    // R2 hit
    access(0, 32'h0000_0100, 4'hF, 0, "R2");
    chk("R2", "hit latency", 32'(last_lat), 32'd1);
    drain();
    chk("R2", "hit beats", 32'(log_n - mark), 32'd0);

    // R3 byte and halfword store hits
    access(1, 32'h0000_0104, 4'b0010, 32'hDEAD_BEEF, "R3");
    chk("R3", "store hit latency", 32'(last_lat), 32'd1);
    drain();
    chk("R3", "store hit beats", 32'(log_n - mark), 32'd0);
    access(0, 32'h0000_0104, 4'hF, 0, "R3");
    access(1, 32'h0000_010C, 4'b1100, 32'h1234_5678, "R3");
    access(0, 32'h0000_010C, 4'hF, 0, "R3");

    // R6 R7 store miss allocates invalid way 1, no write-back of dirty way 0
    access(1, 32'h0000_1104, 4'b0001, 32'h1122_3344, "R6");
    chk("R7", "invalid way used, latency", 32'(last_lat), 32'd2);
    drain();
    chk("R7", "no write-back beats", 32'(log_n - mark), 32'd4);
    chk_beat("R6", 0, 0, 32'h0000_1104);
    access(0, 32'h0000_1104, 4'hF, 0, "R6");
    chk("R6", "allocated hit latency", 32'(last_lat), 32'd1);
    access(0, 32'h0000_0100, 4'hF, 0, "R7");  // way 0 most recent

    // R8 dirty way 1 evicted: 4 writes then wrapped fill
    access(0, 32'h0000_2108, 4'hF, 0, "R8");
    chk("R8", "write-back latency", 32'(last_lat), 32'd6);
    drain();
    chk("R8", "beat count", 32'(log_n - mark), 32'd8);
    chk_beat("R8", 0, 1, 32'h0000_1100);
    chk_beat("R8", 1, 1, 32'h0000_1104);
    chk_beat("R8", 2, 1, 32'h0000_1108);
    chk_beat("R8", 3, 1, 32'h0000_110C);
    chk_beat("R4", 4, 0, 32'h0000_2108);
    chk_beat("R4", 5, 0, 32'h0000_210C);
    chk_beat("R4", 6, 0, 32'h0000_2100);
    chk_beat("R4", 7, 0, 32'h0000_2104);
    chk("R8", "written-back word", bmem[12'h441], gmem[12'h441]);

    // R7 way 0 line survived
    access(0, 32'h0000_0104, 4'hF, 0, "R7");
    chk("R7", "retained hit latency", 32'(last_lat), 32'd1);

    // R8 clean victim: reads only
    access(0, 32'h0000_1100, 4'hF, 0, "R8");
    chk("R8", "clean victim latency", 32'(last_lat), 32'd2);
    drain();
    chk("R8", "clean victim beats", 32'(log_n - mark), 32'd4);
    chk_beat("R8", 0, 0, 32'h0000_1100);
    chk_beat("R8", 3, 0, 32'h0000_110C);

    // R9 bypass, region 1
    access(0, 32'h0800_3F04, 4'hF, 0, "R9");
    chk("R9", "bypass latency", 32'(last_lat), 32'd2);
    drain();
    chk("R9", "bypass beats", 32'(log_n - mark), 32'd1);
    chk_beat("R9", 0, 0, 32'h0800_3F04);
    access(1, 32'h0800_3F08, 4'b0100, 32'hCAFE_F00D, "R9");
    drain();
    chk("R9", "bypass store beats", 32'(log_n - mark), 32'd1);
    chk_beat("R9", 0, 1, 32'h0800_3F08);
    chk("R9", "bypass store memory", bmem[12'hFC2], gmem[12'hFC2]);
    access(0, 32'h0800_3F08, 4'hF, 0, "R9");
    drain();
    chk("R9", "no allocation", 32'(log_n - mark), 32'd1);

    // R10 random ready, mixed traffic
    rnd_mode = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [3:0]  be;
      bit          we;
      int          sel;
      sel = $urandom % 7;
      be  = (sel == 0) ? 4'h1 : (sel == 1) ? 4'h2 : (sel == 2) ? 4'h4 : (sel == 3) ? 4'h8 :
            (sel == 4) ? 4'h3 : (sel == 5) ? 4'hC : 4'hF;
      we  = ($urandom % 3) == 0;
      if (($urandom % 10) == 0)
        a = 32'h0800_3F00 | (32'($urandom % 4) << 2);
      else
        a = (32'($urandom % 3) << 12) | (32'($urandom % 4) << 4) | (32'($urandom % 4) << 2);
      access(we, a, we ? be : 4'hF, $urandom, "R10");
    end
    rnd_mode = 1'b0;
    drain();
    chk("R11", "pending acks", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    report();
  end
endmodule